// File: doc/BRIEF.md
# Reset Cause Flag Register

This block keeps a 16-bit status word that records which events caused the most recent device resets and power-save entries. Each cause has its own flag bit. Each flag is set by one dedicated single-cycle event strobe. Each flag is cleared by its own group of events. Software can load any implemented flag through a write port. When an event clears a flag and another sets it in the same cycle, the clear is applied first and the set second. As a result, the flag of the triggering event is always left set.

The block also selects the 3-bit clock source code that is loaded when a reset occurs. With clock switching enabled, a power-on reset reloads the configured oscillator field. A brown-out, pin, watchdog or software reset keeps the currently running oscillator field. With clock switching disabled, every reset loads the configured field. Detecting the events is done outside this block, and so is the clock switching itself.

The asynchronous active-low reset is released synchronously inside the block. While the block is in reset, the status word and the clock source code are both zero.

Top module: `reset_cause_reg`

## Requirements
- R1: While reset is asserted, and until the first event or write after it, `status` reads 0x0000 and `clk_src` reads 0.
- R2: Each strobe sets its flag in the cycle after the strobe. The flag positions are: trap conflict bit 15, illegal opcode or uninitialized register use bit 14, external pin bit 7, software reset bit 6, watchdog bit 4, sleep bit 3, idle bit 2, brown-out bit 1, power-on bit 0.
- R3: A power-on strobe sets both bit 0 and bit 1. A brown-out strobe sets only bit 1.
- R4: A power-on or brown-out strobe clears every implemented flag except bit 0, before the sets of that cycle are applied.
- R5: No hardware event clears bit 0. Only a software write can clear it.
- R6: A sleep or idle strobe clears both bit 3 and bit 2, before the sets of that cycle are applied.
- R7: When `sw_we` is high, the implemented bits take the value of `sw_wdata`. The event clears and then the event sets of the same cycle are applied on top of that value, so a hardware set wins over the write.
- R8: Bits 13:8 and bit 5 always read 0 and ignore writes.
- R9: With `clksw_en` high, a power-on strobe loads `clk_src` from `cfg_osc`. A brown-out, pin, watchdog or software reset strobe without power-on loads it from `cur_osc`. The load takes effect in the next cycle.
- R10: With `clksw_en` low, any of those reset strobes loads `clk_src` from `cfg_osc`.
- R11: `clk_src` holds its value in any cycle without a power-on, brown-out, pin, watchdog or software reset strobe. This includes cycles with trap, illegal, sleep or idle strobes and cycles with writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_evt | input | 1 | Trap conflict strobe |
| illeg_evt | input | 1 | Illegal opcode or uninitialized register use strobe |
| pin_evt | input | 1 | External pin reset strobe |
| swrst_evt | input | 1 | Software reset instruction strobe |
| wdt_evt | input | 1 | Watchdog expiry strobe |
| sleep_evt | input | 1 | Sleep entry strobe |
| idle_evt | input | 1 | Idle entry strobe |
| bor_evt | input | 1 | Brown-out strobe |
| por_evt | input | 1 | Power-on strobe |
| sw_we | input | 1 | Software write enable for the status word |
| sw_wdata | input | 16 | Software write data |
| clksw_en | input | 1 | Clock switching enabled |
| cfg_osc | input | 3 | Configured oscillator field |
| cur_osc | input | 3 | Current oscillator field |
| status | output | 16 | Reset cause status word |
| clk_src | output | 3 | Clock source code selected at the last reset |

## Verification
A software write and hardware events can land on the status word in the same cycle. The events can also clear and set the same flag in that cycle. The bench provokes this by sweeping all 512 combinations of the nine strobes. Each combination is applied with and without a write of varying data, and with clock switching both on and off. Each resulting status word is judged against a model in the bench: the write is taken first, then the clears, then the sets. In the same cycles the clock source is compared with a selection rule in which power-on has priority.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

  // Flag positions within the status word (decoded by software)
  localparam int POS_TRAP  = 15;
  localparam int POS_ILLEG = 14;
  localparam int POS_PIN   = 7;
  localparam int POS_SWRST = 6;
  localparam int POS_WDT   = 4;
  localparam int POS_SLEEP = 3;
  localparam int POS_IDLE  = 2;
  localparam int POS_BOR   = 1;
  localparam int POS_POR   = 0;

  localparam int STATUS_W  = 16;

  // Implemented-bit mask derived from the positions above
  localparam logic [STATUS_W-1:0] FLAG_MASK =
      (STATUS_W'(1) << POS_TRAP)  | (STATUS_W'(1) << POS_ILLEG) |
      (STATUS_W'(1) << POS_PIN)   | (STATUS_W'(1) << POS_SWRST) |
      (STATUS_W'(1) << POS_WDT)   | (STATUS_W'(1) << POS_SLEEP) |
      (STATUS_W'(1) << POS_IDLE)  | (STATUS_W'(1) << POS_BOR)   |
      (STATUS_W'(1) << POS_POR);

  // Flags wiped by a supply event: everything except the power-on flag
  localparam logic [STATUS_W-1:0] SUPPLY_CLR_MASK =
      FLAG_MASK & ~(STATUS_W'(1) << POS_POR);

  // Flags wiped by any power-save instruction
  localparam logic [STATUS_W-1:0] PSAVE_CLR_MASK =
      (STATUS_W'(1) << POS_SLEEP) | (STATUS_W'(1) << POS_IDLE);

  typedef struct packed {
    logic trap;
    logic illeg;
    logic pin;
    logic swrst;
    logic wdt;
    logic sleep;
    logic idle;
    logic bor;
    logic por;
  } rcf_evt_t;

endpackage

// File: rtl/rcf_rst_sync.sv
module rcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/rcf_event_map.sv
module rcf_event_map
  import rcf_pkg::*;
#(
  parameter int WORD_W = STATUS_W
) (
  input  rcf_evt_t            evt,
  output logic [WORD_W-1:0]   set_mask,
  output logic [WORD_W-1:0]   clr_mask,
  output logic                rst_any,
  output logic                rst_por
);
  localparam logic [WORD_W-1:0] SUP_CLR = WORD_W'(SUPPLY_CLR_MASK);
  localparam logic [WORD_W-1:0] PS_CLR  = WORD_W'(PSAVE_CLR_MASK);

  always_comb begin
    set_mask = '0;
    if (evt.trap)  set_mask[POS_TRAP]  = 1'b1;
    if (evt.illeg) set_mask[POS_ILLEG] = 1'b1;
    if (evt.pin)   set_mask[POS_PIN]   = 1'b1;
    if (evt.swrst) set_mask[POS_SWRST] = 1'b1;
    if (evt.wdt)   set_mask[POS_WDT]   = 1'b1;
    if (evt.sleep) set_mask[POS_SLEEP] = 1'b1;
    if (evt.idle)  set_mask[POS_IDLE]  = 1'b1;
    if (evt.bor)   set_mask[POS_BOR]   = 1'b1;
    if (evt.por) begin
      set_mask[POS_POR] = 1'b1;
      set_mask[POS_BOR] = 1'b1;
    end
  end

  always_comb begin
    clr_mask = '0;
    if (evt.por || evt.bor)     clr_mask = clr_mask | SUP_CLR;
    if (evt.sleep || evt.idle)  clr_mask = clr_mask | PS_CLR;
  end

  always_comb begin
    rst_any = evt.por | evt.bor | evt.pin | evt.wdt | evt.swrst;
    rst_por = evt.por;
  end
endmodule

// File: rtl/rcf_flag_bank.sv
module rcf_flag_bank #(
  parameter int                  WORD_W    = 16,
  parameter logic [WORD_W-1:0]   IMPL_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] set_mask,
  input  logic [WORD_W-1:0] clr_mask,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] flags
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic q;
      logic base;
      logic nxt;
      logic en;

      always_comb begin
        base = wr_en ? wr_data[i] : q;
        nxt  = (base & ~clr_mask[i]) | set_mask[i];
        en   = wr_en | clr_mask[i] | set_mask[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (en) q <= nxt;
      end

      assign flags[i] = q;
    end else begin : g_tie
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rcf_clk_sel.sv
module rcf_clk_sel #(
  parameter int OSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_any,
  input  logic             rst_por,
  input  logic             clksw_en,
  input  logic [OSC_W-1:0] cfg_osc,
  input  logic [OSC_W-1:0] cur_osc,
  output logic [OSC_W-1:0] src
);
  logic [OSC_W-1:0] src_q;
  logic [OSC_W-1:0] src_d;
  logic             use_cfg;

  always_comb begin
    use_cfg = rst_por | ~clksw_en;
    src_d   = use_cfg ? cfg_osc : cur_osc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       src_q <= '0;
    else if (rst_any) src_q <= src_d;
  end

  assign src = src_q;
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg
  import rcf_pkg::*;
#(
  parameter int WORD_W = STATUS_W,
  parameter int OSC_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_evt,
  input  logic              illeg_evt,
  input  logic              pin_evt,
  input  logic              swrst_evt,
  input  logic              wdt_evt,
  input  logic              sleep_evt,
  input  logic              idle_evt,
  input  logic              bor_evt,
  input  logic              por_evt,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_wdata,
  input  logic              clksw_en,
  input  logic [OSC_W-1:0]  cfg_osc,
  input  logic [OSC_W-1:0]  cur_osc,
  output logic [WORD_W-1:0] status,
  output logic [OSC_W-1:0]  clk_src
);
  localparam logic [WORD_W-1:0] IMPL = WORD_W'(FLAG_MASK);

  logic              rst_n_sync;
  rcf_evt_t          evt;
  logic [WORD_W-1:0] set_mask;
  logic [WORD_W-1:0] clr_mask;
  logic              rst_any;
  logic              rst_por;

  always_comb begin
    evt.trap  = trap_evt;
    evt.illeg = illeg_evt;
    evt.pin   = pin_evt;
    evt.swrst = swrst_evt;
    evt.wdt   = wdt_evt;
    evt.sleep = sleep_evt;
    evt.idle  = idle_evt;
    evt.bor   = bor_evt;
    evt.por   = por_evt;
  end

  rcf_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  rcf_event_map #(.WORD_W(WORD_W)) u_event_map (
    .evt      (evt),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .rst_any  (rst_any),
    .rst_por  (rst_por)
  );

  rcf_flag_bank #(.WORD_W(WORD_W), .IMPL_MASK(IMPL)) u_flag_bank (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .wr_en    (sw_we),
    .wr_data  (sw_wdata),
    .flags    (status)
  );

  rcf_clk_sel #(.OSC_W(OSC_W)) u_clk_sel (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .rst_any  (rst_any),
    .rst_por  (rst_por),
    .clksw_en (clksw_en),
    .cfg_osc  (cfg_osc),
    .cur_osc  (cur_osc),
    .src      (clk_src)
  );
endmodule

// File: rtl/rcf_chk.sv
module rcf_chk
  import rcf_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OSC_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              trap_evt,
  input logic              illeg_evt,
  input logic              pin_evt,
  input logic              swrst_evt,
  input logic              wdt_evt,
  input logic              sleep_evt,
  input logic              idle_evt,
  input logic              bor_evt,
  input logic              por_evt,
  input logic              sw_we,
  input logic [OSC_W-1:0]  cfg_osc,
  input logic [OSC_W-1:0]  cur_osc,
  input logic              clksw_en,
  input logic [WORD_W-1:0] status,
  input logic [OSC_W-1:0]  clk_src
);
  localparam logic [WORD_W-1:0] IMPL = WORD_W'(FLAG_MASK);

  logic any_rst;
  assign any_rst = por_evt | bor_evt | pin_evt | wdt_evt | swrst_evt;

  // R3
  por_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> (status[POS_POR] && status[POS_BOR]));

  // R4
  supply_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bor_evt && !trap_evt && !illeg_evt && !pin_evt) |=>
      (!status[POS_TRAP] && !status[POS_ILLEG] && !status[POS_PIN]));

  // R5
  por_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[POS_POR] && !sw_we) |=> status[POS_POR]);

  // R6
  psave_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_evt && !idle_evt) |=> (status[POS_SLEEP] && !status[POS_IDLE]));

  // R7
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_evt && sw_we) |=> status[POS_WDT]);

  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~IMPL) == '0);

  // R9
  clk_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_evt |=> (clk_src == $past(cfg_osc)));

  // R10
  clk_nosw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_rst && !clksw_en) |=> (clk_src == $past(cfg_osc)));

  // R9
  clk_cur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_rst && !por_evt && clksw_en) |=> (clk_src == $past(cur_osc)));

  // R11
  clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_rst |=> $stable(clk_src));
endmodule

bind reset_cause_reg rcf_chk #(.WORD_W(WORD_W), .OSC_W(OSC_W)) u_rcf_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .trap_evt  (trap_evt),
  .illeg_evt (illeg_evt),
  .pin_evt   (pin_evt),
  .swrst_evt (swrst_evt),
  .wdt_evt   (wdt_evt),
  .sleep_evt (sleep_evt),
  .idle_evt  (idle_evt),
  .bor_evt   (bor_evt),
  .por_evt   (por_evt),
  .sw_we     (sw_we),
  .cfg_osc   (cfg_osc),
  .cur_osc   (cur_osc),
  .clksw_en  (clksw_en),
  .status    (status),
  .clk_src   (clk_src)
);

// File: tb/reset_cause_reg_bench.sv
module reset_cause_reg_bench;
  logic        clk;
  logic        rst_n;
  logic        trap_evt, illeg_evt, pin_evt, swrst_evt, wdt_evt;
  logic        sleep_evt, idle_evt, bor_evt, por_evt;
  logic        sw_we;
  logic [15:0] sw_wdata;
  logic        clksw_en;
  logic [2:0]  cfg_osc, cur_osc;
  logic [15:0] status;
  logic [2:0]  clk_src;

  int n_checks;
  int n_fail;
  int cycles;

  logic [15:0] exp_st;
  logic [2:0]  exp_src;

  reset_cause_reg u_reset_cause_reg (
    .clk(clk), .rst_n(rst_n),
    .trap_evt(trap_evt), .illeg_evt(illeg_evt), .pin_evt(pin_evt),
    .swrst_evt(swrst_evt), .wdt_evt(wdt_evt), .sleep_evt(sleep_evt),
    .idle_evt(idle_evt), .bor_evt(bor_evt), .por_evt(por_evt),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .clksw_en(clksw_en),
    .cfg_osc(cfg_osc), .cur_osc(cur_osc),
    .status(status), .clk_src(clk_src)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ev = {trap, illeg, pin, swrst, wdt, sleep, idle, bor, por}
  function automatic logic [15:0] model_status(input logic [15:0] cur, input logic [8:0] ev,
                                               input logic we, input logic [15:0] wd);
    logic [15:0] base, clr, set;
    base = we ? (wd & 16'hC0DF) : cur;
    clr = 16'h0000;
    if (ev[0] || ev[1]) clr = clr | 16'hC0DE;
    if (ev[2] || ev[3]) clr = clr | 16'h000C;
    set = 16'h0000;
    set[15] = ev[8];
    set[14] = ev[7];
    set[7]  = ev[6];
    set[6]  = ev[5];
    set[4]  = ev[4];
    set[3]  = ev[3];
    set[2]  = ev[2];
    set[1]  = ev[1] | ev[0];
    set[0]  = ev[0];
    return (base & ~clr) | set;
  endfunction

  function automatic logic [2:0] model_src(input logic [2:0] cur_src, input logic [8:0] ev,
                                           input logic en, input logic [2:0] cfg,
                                           input logic [2:0] cur);
    if (!(ev[0] | ev[1] | ev[4] | ev[5] | ev[6])) return cur_src;
    if (!en || ev[0]) return cfg;
    return cur;
  endfunction

  task automatic step(input logic [8:0] ev, input logic we, input logic [15:0] wd,
                      input logic en, input logic [2:0] cfg, input logic [2:0] cur,
                      input string st_tag, input string src_tag);
    @(negedge clk);
    {trap_evt, illeg_evt, pin_evt, swrst_evt, wdt_evt, sleep_evt, idle_evt, bor_evt, por_evt} = ev;
    sw_we = we; sw_wdata = wd; clksw_en = en; cfg_osc = cfg; cur_osc = cur;
    exp_st  = model_status(exp_st, ev, we, wd);
    exp_src = model_src(exp_src, ev, en, cfg, cur);
    @(posedge clk);
    #1;
    {trap_evt, illeg_evt, pin_evt, swrst_evt, wdt_evt, sleep_evt, idle_evt, bor_evt, por_evt} = '0;
    sw_we = 1'b0;
    check16(st_tag, status, exp_st);
    check3(src_tag, clk_src, exp_src);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; cycles = 0;
    rst_n = 1'b0;
    {trap_evt, illeg_evt, pin_evt, swrst_evt, wdt_evt, sleep_evt, idle_evt, bor_evt, por_evt} = '0;
    sw_we = 1'b0; sw_wdata = '0; clksw_en = 1'b1; cfg_osc = 3'd5; cur_osc = 3'd2;
    exp_st = '0; exp_src = '0;
    repeat (4) @(posedge clk);
    #1;
    check16("R1 status in reset", status, 16'h0000);
    check3("R1 clk_src in reset", clk_src, 3'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check16("R1 status after release", status, 16'h0000);
    check3("R1 clk_src after release", clk_src, 3'd0);

    // Directed cases
    step(9'h001, 1'b0, 16'h0, 1'b1, 3'd5, 3'd2, "R3 power-on flags", "R9 power-on source");
    check16("R3 power-on literal", status, 16'h0003);
    step(9'h000, 1'b1, 16'hFFFF, 1'b1, 3'd5, 3'd2, "R8 write all ones", "R11 write holds source");
    check16("R8 unused bits zero", status, 16'hC0DF);
    step(9'h002, 1'b0, 16'h0, 1'b1, 3'd5, 3'd2, "R4 brown-out clears", "R9 brown-out source");
    check16("R4 brown-out literal", status, 16'h0003);
    step(9'h040, 1'b0, 16'h0, 1'b1, 3'd6, 3'd1, "R5 pin keeps power-on flag", "R9 pin source");
    step(9'h008, 1'b0, 16'h0, 1'b1, 3'd6, 3'd1, "R6 sleep sets", "R11 sleep holds source");
    step(9'h004, 1'b0, 16'h0, 1'b1, 3'd6, 3'd1, "R6 idle clears sleep", "R11 idle holds source");
    check16("R6 idle literal", status, 16'h0087);
    step(9'h010, 1'b1, 16'h0000, 1'b1, 3'd6, 3'd1, "R7 set wins over write", "R9 watchdog source");
    check16("R7 watchdog literal", status, 16'h0010);
    step(9'h020, 1'b0, 16'h0, 1'b0, 3'd3, 3'd7, "R2 software reset flag", "R10 switching off");
    step(9'h100, 1'b0, 16'h0, 1'b1, 3'd0, 3'd4, "R2 trap flag", "R11 trap holds source");
    step(9'h080, 1'b0, 16'h0, 1'b1, 3'd0, 3'd4, "R2 illegal flag", "R11 illegal holds source");

    // Sweep over every strobe combination and four write/switch variants
    for (int e = 0; e < 512; e++) begin
      for (int v = 0; v < 4; v++) begin
        logic [15:0] wd;
        logic [2:0]  cfg;
        wd  = 16'(e * 16'd40503) ^ 16'h5A3C ^ 16'(v * 16'd4369);
        cfg = 3'(e) ^ 3'(v);
        step(9'(e), v[0], wd, v[1], cfg, ~cfg,
             "R2/R3/R4/R5/R6/R7/R8 sweep status", "R9/R10/R11 sweep source");
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule